// File: doc/BRIEF.md
# DDR Extended Mode Register Programming Sequencer

This block sits on the controller side of a DDR SDRAM interface. It programs the device's extended mode register. A client hands it one request through a ready/valid handshake. The request carries two choices: whether the delay-locked loop (DLL) is to be switched off, and whether reduced output drive is wanted. The request also carries the base mode register value that the controller currently uses. The block holds the request until the memory reports that every bank is idle and that no burst is running. It then puts out a load-mode-register command with the extended-register bank select and an address word built from the request.

When the request turns the DLL on, the block spaces out a fixed gap of NOP cycles after the extended load. It then issues a second load to the base register, with the DLL-reset bit set. Whenever the DLL has just been enabled or reset, the block keeps `read_allowed_o` low for a parameterised lock time, so that no READ goes out before the loop has locked. A self-refresh-exit pulse restarts that lock wait and issues no command. Commands appear one per cycle on the command port: either a load or a NOP.

Top module: `ddr_emr_prog`

## Requirements
- R1: `req_ready_o` is high only while the sequencer is idle. A request offered while it is busy sees `req_ready_o` low and does not change the commands of the sequence in progress.
- R2: A load command is never issued unless `banks_idle_i` is high and `burst_active_i` is low at the clock edge before it. The extended load appears in the cycle after the first such edge.
- R3: The extended load drives `cmd_type_o`=1 (load), `cmd_ba_o`=2'b01 and `cmd_addr_o[0]`=1 to disable the DLL or 0 to enable it. Bits `cmd_addr_o[13:2]` are all 0.
- R4: `cmd_addr_o[1]` of the extended load equals the reduced-drive request only when `DEV_WIDTH` is 16. For any other width it is 0.
- R5: When bit 0 of the extended load is 0, a base load follows with `cmd_ba_o`=2'b00 and `cmd_addr_o` equal to `base_mr_i` with bit 8 forced to 1.
- R6: A request that disables the DLL produces exactly one load command and no base load.
- R7: Every load is followed by exactly `LMR_GAP` NOP cycles. `done_o` pulses for one cycle in the last NOP cycle of the sequence, and `req_ready_o` is high in the cycle after that.
- R8: After the base load with DLL reset, `read_allowed_o` is low for `LOCK_CYCLES` cycles and goes high in the next cycle.
- R9: A one-cycle pulse on `sr_exit_i` restarts the lock wait (`read_allowed_o` low for `LOCK_CYCLES` cycles, then high) and issues no command. This holds even if a wait is already under way.
- R10: After reset, `req_ready_o`=1, `done_o`=0 and `read_allowed_o`=1, and the command port shows a NOP.
- R11: In every cycle that is not a load, `cmd_type_o`=0 (NOP), `cmd_ba_o`=0 and `cmd_addr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_dll_off_i | input | 1 | 1 = disable DLL, 0 = enable DLL |
| req_reduced_i | input | 1 | 1 = ask for reduced output drive |
| base_mr_i | input | 14 | Base mode register value used for the DLL-reset load |
| banks_idle_i | input | 1 | All banks idle |
| burst_active_i | input | 1 | A burst is in progress |
| sr_exit_i | input | 1 | One-cycle pulse on self-refresh exit |
| cmd_type_o | output | 1 | 1 = load mode register, 0 = NOP |
| cmd_ba_o | output | 2 | Bank address of the command |
| cmd_addr_o | output | 14 | Address bus of the command |
| done_o | output | 1 | Sequence finished pulse |
| read_allowed_o | output | 1 | READ may be issued |

## Verification
The bench holds the banks busy, or a burst active, for chosen and random numbers of cycles. A sequencer that ignored either gate would put out the extended load early, and one with an extra stage would put it out late. The bench checks the exact cycle of each load, the gap length and the `done_o` cycle, so a gap that is one cycle short or one cycle long shows up. It offers a request with opposite fields while the sequencer is busy, to catch a design that accepts or latches it. A second instance with narrow width catches reduced drive leaking into bit 1. The lock window is measured to the cycle after the reset load and after self-refresh exit, including a retrigger in mid-window, so a counter that is off by one or that is not restarted is reported.

// File: rtl/ddr_emr_pkg.sv
package ddr_emr_pkg;
  typedef enum logic {CMD_NOP = 1'b0, CMD_LMR = 1'b1} cmd_e;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_EMR, S_GAP_E, S_MR, S_GAP_M
  } seq_state_e;
  localparam logic [1:0] BA_BASE = 2'b00;
  localparam logic [1:0] BA_EXT  = 2'b01;
  localparam int unsigned DLL_RST_BIT = 8;
endpackage

// File: rtl/ddr_emr_word.sv
module ddr_emr_word #(
  parameter int unsigned AW        = 14,
  parameter int unsigned DEV_WIDTH = 16
) (
  input  logic          dll_off_i,
  input  logic          reduced_i,
  input  logic [AW-1:0] base_mr_i,
  output logic [AW-1:0] emr_addr_o,
  output logic [AW-1:0] mr_addr_o
);
  logic drive_bit;

  generate
    if (DEV_WIDTH == 16) begin : g_wide
      assign drive_bit = reduced_i;
    end else begin : g_narrow
      logic unused_red;
      assign unused_red = reduced_i;
      assign drive_bit  = 1'b0;
    end
  endgenerate

  always_comb begin
    emr_addr_o    = '0;
    emr_addr_o[0] = dll_off_i;
    emr_addr_o[1] = drive_bit;
    mr_addr_o     = base_mr_i;
    mr_addr_o[ddr_emr_pkg::DLL_RST_BIT] = 1'b1;
  end
endmodule

// File: rtl/ddr_emr_down_cnt.sv
module ddr_emr_down_cnt #(
  parameter int unsigned MAX = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);
  localparam int unsigned CW = $clog2(MAX + 2);
  localparam logic [CW-1:0] LOAD_VAL = CW'(MAX);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  assert_count_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> $past(cnt_q) - cnt_q == CW'(1));
endmodule

// File: rtl/ddr_emr_prog.sv
module ddr_emr_prog #(
  parameter int unsigned AW          = 14,
  parameter int unsigned DEV_WIDTH   = 16,
  parameter int unsigned LMR_GAP     = 2,
  parameter int unsigned LOCK_CYCLES = 200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_dll_off_i,
  input  logic          req_reduced_i,
  input  logic [AW-1:0] base_mr_i,
  input  logic          banks_idle_i,
  input  logic          burst_active_i,
  input  logic          sr_exit_i,
  output logic          cmd_type_o,
  output logic [1:0]    cmd_ba_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic          done_o,
  output logic          read_allowed_o
);
  import ddr_emr_pkg::*;

  localparam int unsigned GAP_MAX = (LMR_GAP > 0) ? LMR_GAP - 1 : 0;

  seq_state_e    state_q, state_d;
  logic          dll_off_q, reduced_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] emr_addr, mr_addr;
  logic          gap_zero, lock_zero;
  logic          accept, bus_quiet;

  assign accept    = req_valid_i && (state_q == S_IDLE);
  assign bus_quiet = banks_idle_i && !burst_active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      dll_off_q <= 1'b1;
      reduced_q <= 1'b0;
      base_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        dll_off_q <= req_dll_off_i;
        reduced_q <= req_reduced_i;
        base_q    <= base_mr_i;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:  if (req_valid_i) state_d = S_WAIT;
      S_WAIT:  if (bus_quiet)   state_d = S_EMR;
      S_EMR:   state_d = S_GAP_E;
      S_GAP_E: if (gap_zero)    state_d = dll_off_q ? S_IDLE : S_MR;
      S_MR:    state_d = S_GAP_M;
      S_GAP_M: if (gap_zero)    state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  ddr_emr_word #(.AW(AW), .DEV_WIDTH(DEV_WIDTH)) u_word (
    .dll_off_i (dll_off_q),
    .reduced_i (reduced_q),
    .base_mr_i (base_q),
    .emr_addr_o(emr_addr),
    .mr_addr_o (mr_addr)
  );

  ddr_emr_down_cnt #(.MAX(GAP_MAX)) u_gap (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i((state_q == S_EMR) || (state_q == S_MR)),
    .zero_o(gap_zero)
  );

  // lock wait restarts on any DLL enable, DLL reset or self-refresh exit
  ddr_emr_down_cnt #(.MAX(LOCK_CYCLES)) u_lock (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(((state_q == S_EMR) && !dll_off_q) || (state_q == S_MR) || sr_exit_i),
    .zero_o(lock_zero)
  );

  always_comb begin
    cmd_type_o = CMD_NOP;
    cmd_ba_o   = '0;
    cmd_addr_o = '0;
    if (state_q == S_EMR) begin
      cmd_type_o = CMD_LMR;
      cmd_ba_o   = BA_EXT;
      cmd_addr_o = emr_addr;
    end else if (state_q == S_MR) begin
      cmd_type_o = CMD_LMR;
      cmd_ba_o   = BA_BASE;
      cmd_addr_o = mr_addr;
    end
  end

  assign req_ready_o    = (state_q == S_IDLE);
  assign done_o         = gap_zero && ((state_q == S_GAP_M) || ((state_q == S_GAP_E) && dll_off_q));
  assign read_allowed_o = lock_zero;

  assert_busy_refuse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_idle_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_type_o == CMD_LMR && cmd_ba_o == BA_EXT) |-> $past(banks_idle_i && !burst_active_i));

  assert_ext_reserved_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_type_o == CMD_LMR && cmd_ba_o == BA_EXT) |-> cmd_addr_o[AW-1:2] == '0);

  assert_narrow_drive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DEV_WIDTH != 16 && cmd_type_o == CMD_LMR && cmd_ba_o == BA_EXT) |-> !cmd_addr_o[1]);

  assert_dll_reset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_type_o == CMD_LMR && cmd_ba_o == BA_BASE) |-> cmd_addr_o[DLL_RST_BIT]);

  assert_gap_nop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_type_o == CMD_LMR) |=> (cmd_type_o == CMD_NOP));

  assert_lock_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_type_o == CMD_LMR && cmd_ba_o == BA_BASE) |=> !read_allowed_o);

  assert_sr_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_exit_i |=> !read_allowed_o);

  assert_nop_clean_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_type_o == CMD_NOP) |-> (cmd_ba_o == 2'b00 && cmd_addr_o == '0));
endmodule

// File: tb/ddr_emr_prog_tb.sv
`timescale 1ns/1ps
module ddr_emr_prog_tb_top;
  localparam int unsigned AW   = 14;
  localparam int unsigned GAP  = 3;
  localparam int unsigned LOCK = 200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_dll_off = 1'b0;
  logic          req_reduced = 1'b0;
  logic [AW-1:0] base_mr = '0;
  logic          banks_idle = 1'b1;
  logic          burst_active = 1'b0;
  logic          sr_exit = 1'b0;

  logic          ready, cmd_type, done, rd_ok;
  logic [1:0]    cmd_ba;
  logic [AW-1:0] cmd_addr;
  logic          ready_n, cmd_type_n, done_n, rd_ok_n;
  logic [1:0]    cmd_ba_n;
  logic [AW-1:0] cmd_addr_n;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ddr_emr_prog #(.AW(AW), .DEV_WIDTH(16), .LMR_GAP(GAP), .LOCK_CYCLES(LOCK)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(ready),
    .req_dll_off_i(req_dll_off), .req_reduced_i(req_reduced), .base_mr_i(base_mr),
    .banks_idle_i(banks_idle), .burst_active_i(burst_active), .sr_exit_i(sr_exit),
    .cmd_type_o(cmd_type), .cmd_ba_o(cmd_ba), .cmd_addr_o(cmd_addr),
    .done_o(done), .read_allowed_o(rd_ok));

  ddr_emr_prog #(.AW(AW), .DEV_WIDTH(8), .LMR_GAP(GAP), .LOCK_CYCLES(LOCK)) dut_n_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(ready_n),
    .req_dll_off_i(req_dll_off), .req_reduced_i(req_reduced), .base_mr_i(base_mr),
    .banks_idle_i(banks_idle), .burst_active_i(burst_active), .sr_exit_i(sr_exit),
    .cmd_type_o(cmd_type_n), .cmd_ba_o(cmd_ba_n), .cmd_addr_o(cmd_addr_n),
    .done_o(done_n), .read_allowed_o(rd_ok_n));

  function automatic logic [AW-1:0] exp_ext(input logic off, input logic red, input bit wide);
    logic [AW-1:0] a;
    a    = '0;
    a[0] = off;
    a[1] = red & wide;
    return a;
  endfunction

  function automatic logic [AW-1:0] exp_base(input logic [AW-1:0] b);
    return b | 14'h0100;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // one request; bank busy for h1 cycles, then burst for h2 cycles
  task automatic run_seq(input logic off, input logic red, input logic [AW-1:0] base,
                         input int h1, input int h2);
    int h, n_lmr, ext_i, mr_i, done_i, hi_i;
    h = h1 + h2;
    n_lmr = 0; ext_i = -1; mr_i = -1; done_i = -1; hi_i = -1;
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_dll_off = off; req_reduced = red; base_mr = base;
    banks_idle = (h1 == 0); burst_active = 1'b0;
    for (int i = 1; i < 700; i++) begin
      @(negedge clk);
      if (i <= 2) chk(ready == 1'b0, "R1 ready while busy", ready, 0);
      if (cmd_type) begin
        n_lmr++;
        if (n_lmr == 1) begin
          ext_i = i;
          chk(i == h + 1, "R2 ext load cycle", i, h + 1);
          chk(cmd_ba == 2'b01, "R3 ext bank", cmd_ba, 1);
          chk(cmd_addr == exp_ext(off, red, 1'b1), "R3 ext addr", cmd_addr, exp_ext(off, red, 1'b1));
          chk(cmd_addr_n == exp_ext(off, red, 1'b0), "R4 narrow ext addr", cmd_addr_n, exp_ext(off, red, 1'b0));
        end else if (n_lmr == 2) begin
          mr_i = i;
          chk(i == ext_i + GAP + 1, "R7 gap before base", i, ext_i + GAP + 1);
          chk(cmd_ba == 2'b00, "R5 base bank", cmd_ba, 0);
          chk(cmd_addr == exp_base(base), "R5 base addr", cmd_addr, exp_base(base));
        end
      end else if (cmd_ba != 2'b00 || cmd_addr != '0) begin
        chk(1'b0, "R11 nop fields", {cmd_ba, cmd_addr}, 0);
      end
      if (mr_i > 0 && i > mr_i && i <= mr_i + int'(LOCK) && rd_ok)
        chk(1'b0, "R8 read early", i, mr_i + LOCK + 1);
      if (mr_i > 0 && hi_i < 0 && rd_ok) hi_i = i;
      if (done) begin
        if (done_i >= 0) chk(1'b0, "R7 done twice", i, done_i);
        done_i = i;
      end
      if (done_i == i - 1) chk(ready == 1'b1, "R7 ready after done", ready, 1);
      // drive for this cycle
      if (i <= 2) begin
        req_valid = 1'b1; req_dll_off = ~off; req_reduced = ~red; base_mr = ~base;
      end else req_valid = 1'b0;
      banks_idle   = (i >= h1);
      burst_active = (i >= h1) && (i < h);
      if (done_i > 0 && i > done_i && (off || hi_i > 0)) break;
    end
    if (off) begin
      chk(n_lmr == 1, "R6 single load", n_lmr, 1);
      chk(done_i == ext_i + GAP, "R7 done cycle", done_i, ext_i + GAP);
    end else begin
      chk(n_lmr == 2, "R5 two loads", n_lmr, 2);
      chk(done_i == mr_i + GAP, "R7 done cycle", done_i, mr_i + GAP);
      chk(hi_i == mr_i + LOCK + 1, "R8 lock release", hi_i, mr_i + LOCK + 1);
    end
  endtask

  task automatic sr_test(input int mid);
    int hi;
    hi = -1;
    @(negedge clk);
    sr_exit = 1'b1;
    if (mid > 0) begin
      @(negedge clk); sr_exit = 1'b0;
      repeat (mid - 1) @(negedge clk);
      sr_exit = 1'b1;
    end
    for (int n = 1; n < 400; n++) begin
      @(negedge clk);
      if (n == 1) sr_exit = 1'b0;
      if (cmd_type) chk(1'b0, "R9 command on sr exit", cmd_type, 0);
      if (rd_ok) begin hi = n; break; end
    end
    chk(hi == LOCK + 1, "R9 sr lock window", hi, LOCK + 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R10 reset ready", ready, 1);
    chk(done == 1'b0, "R10 reset done", done, 0);
    chk(rd_ok == 1'b1, "R10 reset read_allowed", rd_ok, 1);
    chk(cmd_type == 1'b0 && cmd_ba == 2'b00 && cmd_addr == '0, "R10 reset nop",
        {cmd_type, cmd_ba, cmd_addr}, 0);

    run_seq(1'b0, 1'b1, 14'h0033, 1, 0);
    run_seq(1'b1, 1'b1, 14'h3fff, 0, 1);
    run_seq(1'b1, 1'b0, 14'h0000, 12, 17);
    run_seq(1'b0, 1'b0, 14'h2e01, 0, 30);
    sr_test(0);
    sr_test(60);
    for (int k = 0; k < 24; k++) begin
      run_seq(1'($urandom), 1'($urandom), AW'($urandom), int'($urandom % 9), int'($urandom % 9) + 1);
    end
    sr_test(5);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule